// File: doc/BRIEF.md
# Active video window border generator

This block qualifies every pixel of a video encoder output as active picture or border. It compares an externally supplied horizontal pixel count and line count against a programmed rectangle. Inside the rectangle the incoming pixel word passes through. Outside it a programmable border colour takes its place. The qualifier and the selected pixel leave the block from one output register, so they stay aligned with each other.

The horizontal limits are two 11-bit values. Each is given as an 8-bit low part and a 3-bit high part. A limit above the largest legal count for the selected standard disables the picture for the whole line: 1715 for the 525-line M-system, 1727 for the other systems. The vertical limits are raw 9-bit codes. Their ninth bits come from a mode register shared with other functions. Each code maps to a line number through an offset, and that offset depends on the standard and differs between the first and the last line. Code zero corresponds to the first field synchronisation pulse. The counters, the register bus and the sync generation all sit outside this block.

Top module: `vid_window_border`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, active_o is 0 and pix_o is all zeros.
- R2: The horizontal start is {hs_hi, hs_lo} and the end is {he_hi, he_lo}, each 11 bits wide. A pixel is horizontally inside when start <= h_cnt < end, so the start count is inside and the end count is not.
- R3: When the start is not less than the end (start > end or start == end), no pixel of the line is active.
- R4: When either horizontal limit exceeds 1715 with std_m = 1, or exceeds 1727 with std_m = 0, no pixel of the line is active. A limit equal to the maximum is allowed.
- R5: The first active line is {fal_msb, fal_lo} + 4 when std_m = 1 and {fal_msb, fal_lo} + 1 when std_m = 0. No earlier line is active.
- R6: The last active line is {lal_msb, lal_lo} + 3 when std_m = 1 and {lal_msb, lal_lo} when std_m = 0. That line is active and no later line is.
- R7: When a pixel is active, the next cycle shows active_o = 1 and pix_o equal to that cycle's pix_in. The same one-cycle latency holds on consecutive cycles.
- R8: When a pixel is not active, the next cycle shows active_o = 0 and pix_o equal to that cycle's border.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| std_m | input | 1 | 1 = 525-line M-system (60 Hz), 0 = other systems (50 Hz) |
| h_cnt | input | HW (11) | Horizontal pixel count |
| line_cnt | input | LW (10) | Line count, 0 at the first field sync pulse |
| hs_lo | input | 8 | Horizontal start, low part |
| hs_hi | input | HW-8 (3) | Horizontal start, high part |
| he_lo | input | 8 | Horizontal end, low part |
| he_hi | input | HW-8 (3) | Horizontal end, high part |
| fal_lo | input | VW-1 (8) | First-line code, low bits |
| fal_msb | input | 1 | First-line code, ninth bit from the shared mode register |
| lal_lo | input | VW-1 (8) | Last-line code, low bits |
| lal_msb | input | 1 | Last-line code, ninth bit from the shared mode register |
| pix_in | input | PW (24) | Incoming pixel word |
| border | input | PW (24) | Border colour |
| active_o | output | 1 | Registered active-picture qualifier |
| pix_o | output | PW (24) | Registered pixel or border colour |

## Verification
The bench builds the block with its default parameters: 11-bit horizontal limits, 9-bit vertical codes, a 10-bit line count and 24-bit pixels. These widths reach both legal horizontal maxima and the first illegal count above each. They also let the ninth code bit place the first and last lines beyond line 255. With the 10-bit line count, the M-system offsets can be checked at both vertical edges.

// File: rtl/vwb_pkg.sv
package vwb_pkg;
  // Largest legal horizontal limit per standard
  localparam int H_MAX_M   = 1715;
  localparam int H_MAX_O   = 1727;
  // Offsets from raw vertical code to line number
  localparam int FIRST_OFS_M = 4;
  localparam int FIRST_OFS_O = 1;
  localparam int LAST_OFS_M  = 3;
  localparam int LAST_OFS_O  = 0;
endpackage

// File: rtl/vwb_hlimits.sv
module vwb_hlimits #(
  parameter int HW = 11
) (
  input  logic          std_m,
  input  logic [HW-1:0] h_cnt,
  input  logic [HW-1:0] hstart,
  input  logic [HW-1:0] hend,
  output logic          h_act
);
  import vwb_pkg::*;

  localparam logic [HW-1:0] MAX_M = HW'(H_MAX_M);
  localparam logic [HW-1:0] MAX_O = HW'(H_MAX_O);

  logic [HW-1:0] hmax;
  logic          in_range;
  logic          ordered;
  logic          in_span;

  always_comb begin
    hmax     = std_m ? MAX_M : MAX_O;
    in_range = (hstart <= hmax) && (hend <= hmax);
    ordered  = hstart < hend;
    in_span  = (h_cnt >= hstart) && (h_cnt < hend);
    h_act    = in_range && ordered && in_span;
  end

  // R4: a limit past the standard's maximum blanks the line
  always_comb begin
    if ((std_m && (hend > HW'(H_MAX_M))) || (!std_m && (hend > HW'(H_MAX_O))))
      a_r4_end_range: assert (!h_act);
  end

  // R3: reversed or equal limits blank the line
  always_comb begin
    if (!(hend > hstart))
      a_r3_order: assert (!h_act);
  end
endmodule

// File: rtl/vwb_vlimits.sv
module vwb_vlimits #(
  parameter int VW = 9,
  parameter int LW = 10
) (
  input  logic          std_m,
  input  logic [LW-1:0] line_cnt,
  input  logic [VW-1:0] first_code,
  input  logic [VW-1:0] last_code,
  output logic          v_act
);
  import vwb_pkg::*;

  localparam int CW = (LW > VW + 1) ? LW : VW + 1;

  logic [CW-1:0] line_x;
  logic [CW-1:0] first_line;
  logic [CW-1:0] last_line;

  always_comb begin
    line_x     = CW'(line_cnt);
    first_line = CW'(first_code) + (std_m ? CW'(FIRST_OFS_M) : CW'(FIRST_OFS_O));
    last_line  = CW'(last_code)  + (std_m ? CW'(LAST_OFS_M)  : CW'(LAST_OFS_O));
    v_act      = (line_x >= first_line) && (line_x <= last_line);
  end

  // R5: in the M-system the line three after the code is still blank
  always_comb begin
    if (std_m && (line_x == CW'(first_code) + CW'(3)))
      a_r5_m_before_first: assert (!v_act);
  end

  // R6: in other systems the line one past the code is blank
  always_comb begin
    if (!std_m && (line_x == CW'(last_code) + CW'(1)))
      a_r6_o_after_last: assert (!v_act);
  end
endmodule

// File: rtl/vid_window_border.sv
module vid_window_border #(
  parameter int HW = 11,
  parameter int VW = 9,
  parameter int LW = 10,
  parameter int PW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          std_m,
  input  logic [HW-1:0] h_cnt,
  input  logic [LW-1:0] line_cnt,
  input  logic [7:0]    hs_lo,
  input  logic [HW-9:0] hs_hi,
  input  logic [7:0]    he_lo,
  input  logic [HW-9:0] he_hi,
  input  logic [VW-2:0] fal_lo,
  input  logic          fal_msb,
  input  logic [VW-2:0] lal_lo,
  input  logic          lal_msb,
  input  logic [PW-1:0] pix_in,
  input  logic [PW-1:0] border,
  output logic          active_o,
  output logic [PW-1:0] pix_o
);
  logic [HW-1:0] hstart;
  logic [HW-1:0] hend;
  logic [VW-1:0] first_code;
  logic [VW-1:0] last_code;
  logic          h_act;
  logic          v_act;
  logic          act_c;

  assign hstart     = {hs_hi, hs_lo};
  assign hend       = {he_hi, he_lo};
  assign first_code = {fal_msb, fal_lo};
  assign last_code  = {lal_msb, lal_lo};

  vwb_hlimits #(.HW(HW)) u_h (
    .std_m  (std_m),
    .h_cnt  (h_cnt),
    .hstart (hstart),
    .hend   (hend),
    .h_act  (h_act)
  );

  vwb_vlimits #(.VW(VW), .LW(LW)) u_v (
    .std_m      (std_m),
    .line_cnt   (line_cnt),
    .first_code (first_code),
    .last_code  (last_code),
    .v_act      (v_act)
  );

  assign act_c = h_act && v_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_o <= 1'b0;
      pix_o    <= '0;
    end else begin
      active_o <= act_c;
      pix_o    <= act_c ? pix_in : border;
    end
  end

  // R7: active output carries the previous cycle's pixel
  a_r7_pass: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && active_o) |-> (pix_o == $past(pix_in)));

  // R8: border output carries the previous cycle's border colour
  a_r8_border: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !active_o) |-> (pix_o == $past(border)));

  // R1: first cycle after reset shows the cleared output
  a_r1_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!active_o && pix_o == '0));

  // R3: reversed limits at the ports never yield an active output
  a_r3_ports: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past({hs_hi, hs_lo}) >= $past({he_hi, he_lo}))) |-> !active_o);
endmodule

// File: tb/vid_window_border_tb.sv
module vid_window_border_tb;
  localparam int PW = 24;

  typedef struct packed {
    logic        m;
    logic [10:0] hs;
    logic [10:0] he;
    logic [10:0] h;
    logic [8:0]  fal;
    logic [8:0]  lal;
    logic [9:0]  line;
    logic        exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 11'd100,  11'd300,  11'd100,  9'd20,  9'd300, 10'd21,  1'b1, 4'd2}, // R2 start inside, R5 first=21
    '{1'b0, 11'd100,  11'd300,  11'd299,  9'd20,  9'd300, 10'd150, 1'b1, 4'd2}, // R2
    '{1'b0, 11'd100,  11'd300,  11'd300,  9'd20,  9'd300, 10'd150, 1'b0, 4'd2}, // R2 end excluded
    '{1'b0, 11'd100,  11'd300,  11'd99,   9'd20,  9'd300, 10'd150, 1'b0, 4'd8}, // R8
    '{1'b0, 11'd100,  11'd300,  11'd150,  9'd20,  9'd300, 10'd20,  1'b0, 4'd5}, // R5
    '{1'b1, 11'd100,  11'd300,  11'd150,  9'd20,  9'd300, 10'd24,  1'b1, 4'd5}, // R5 M first=24
    '{1'b1, 11'd100,  11'd300,  11'd150,  9'd20,  9'd300, 10'd23,  1'b0, 4'd5}, // R5
    '{1'b0, 11'd100,  11'd300,  11'd150,  9'd20,  9'd300, 10'd300, 1'b1, 4'd6}, // R6 last=300
    '{1'b0, 11'd100,  11'd300,  11'd150,  9'd20,  9'd300, 10'd301, 1'b0, 4'd6}, // R6
    '{1'b1, 11'd100,  11'd300,  11'd150,  9'd20,  9'd300, 10'd303, 1'b1, 4'd6}, // R6 M last=303
    '{1'b1, 11'd100,  11'd300,  11'd150,  9'd20,  9'd300, 10'd304, 1'b0, 4'd6}, // R6
    '{1'b0, 11'd300,  11'd100,  11'd200,  9'd20,  9'd300, 10'd150, 1'b0, 4'd3}, // R3 reversed
    '{1'b0, 11'd200,  11'd200,  11'd200,  9'd20,  9'd300, 10'd150, 1'b0, 4'd3}, // R3 equal
    '{1'b1, 11'd100,  11'd1715, 11'd1714, 9'd20,  9'd300, 10'd150, 1'b1, 4'd4}, // R4 max allowed
    '{1'b1, 11'd100,  11'd1716, 11'd1000, 9'd20,  9'd300, 10'd150, 1'b0, 4'd4}, // R4 over M max
    '{1'b0, 11'd100,  11'd1716, 11'd1000, 9'd20,  9'd300, 10'd150, 1'b1, 4'd4}, // R4 legal in 50 Hz
    '{1'b0, 11'd100,  11'd1728, 11'd1000, 9'd20,  9'd300, 10'd150, 1'b0, 4'd4}, // R4 over
    '{1'b0, 11'd1728, 11'd1800, 11'd1750, 9'd20,  9'd300, 10'd150, 1'b0, 4'd4}, // R4 start over
    '{1'b0, 11'd100,  11'd300,  11'd150,  9'd300, 9'd400, 10'd302, 1'b1, 4'd5}, // R5 ninth bit
    '{1'b0, 11'd100,  11'd300,  11'd150,  9'd300, 9'd400, 10'd300, 1'b0, 4'd5}, // R5 ninth bit
    '{1'b0, 11'd100,  11'd300,  11'd150,  9'd20,  9'd260, 10'd260, 1'b1, 4'd6}  // R6 ninth bit
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          std_m = 1'b0;
  logic [10:0]   h_cnt = '0;
  logic [9:0]    line_cnt = '0;
  logic [10:0]   hs = 11'd100;
  logic [10:0]   he = 11'd300;
  logic [8:0]    fal = 9'd20;
  logic [8:0]    lal = 9'd300;
  logic [PW-1:0] pix_in = 24'h123456;
  logic [PW-1:0] border = 24'h808080;
  logic          active_o;
  logic [PW-1:0] pix_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  vid_window_border u_dut (
    .clk(clk), .rst(rst), .std_m(std_m), .h_cnt(h_cnt), .line_cnt(line_cnt),
    .hs_lo(hs[7:0]), .hs_hi(hs[10:8]), .he_lo(he[7:0]), .he_hi(he[10:8]),
    .fal_lo(fal[7:0]), .fal_msb(fal[8]), .lal_lo(lal[7:0]), .lal_msb(lal[8]),
    .pix_in(pix_in), .border(border), .active_o(active_o), .pix_o(pix_o)
  );

  task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v, input logic [PW-1:0] p);
    std_m = v.m; hs = v.hs; he = v.he; h_cnt = v.h;
    fal = v.fal; lal = v.lal; line_cnt = v.line; pix_in = p;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    vec_t prev;
    logic [PW-1:0] prev_pix;
    // R1: reset state, with inputs that would otherwise be active
    apply(VECS[0], 24'hABCDEF);
    repeat (3) @(negedge clk);
    check("R1 active in reset", {23'd0, active_o}, '0);
    check("R1 pix in reset", pix_o, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 active after release", {23'd0, active_o}, 24'd1);

    // Table: back-to-back, each result checked one cycle after its input
    apply(VECS[0], 24'h111111);
    prev = VECS[0]; prev_pix = 24'h111111;
    for (int i = 1; i <= NV; i++) begin
      @(negedge clk);
      check($sformatf("R%0d vec%0d active", prev.req, i-1), {23'd0, active_o}, {23'd0, prev.exp});
      check($sformatf("R%0d vec%0d pix", prev.exp ? 7 : 8, i-1), pix_o,
            prev.exp ? prev_pix : border);
      if (i < NV) begin
        prev = VECS[i];
        prev_pix = 24'h111111 + i * 24'h010203;
        apply(prev, prev_pix);
      end
    end

    // R7: streaming pixels inside the window, one-cycle lag
    apply(VECS[1], 24'h000001);
    for (int k = 2; k < 6; k++) begin
      @(negedge clk);
      check("R7 stream", pix_o, 24'(k - 1));
      pix_in = 24'(k);
    end

    // R8: border colour change follows one cycle later outside
    apply(VECS[3], 24'h555555);
    border = 24'h0F0F0F;
    @(negedge clk);
    check("R8 border", pix_o, 24'h0F0F0F);
    border = 24'hF0F0F0;
    @(negedge clk);
    check("R8 border change", pix_o, 24'hF0F0F0);

    // R1: reset mid-run clears outputs
    apply(VECS[1], 24'h777777);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run active", {23'd0, active_o}, '0);
    check("R1 mid-run pix", pix_o, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R7 after reset", pix_o, 24'h777777);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule